// File: doc/BRIEF.md
# SDRAM Gapless Read Sequencer

This block sits on the controller side of a synchronous DRAM. It takes column read requests from a valid/ready queue port and turns them into READ and NOP commands on the DRAM command bus. Each request carries a bank, a column, a wanted word count of 1 to 4 and a tag. Every bank is assumed to already have an open row. The DRAM burst length is programmed to 4. A request that wants fewer than 4 words is cut short by the next READ. When no further READ comes, the burst runs out in full on the bus.

The sequencer decides when each READ goes out. It places the next READ so that its first data word lands on the cycle right after the last wanted word of the burst before it. In that rule the CAS latency cancels, so a READ carrying n wanted words lets the next READ follow exactly n cycles later. The bank may be the same or a different one. The CAS latency is chosen by a static configuration pin, either 2 or 3. A short pipeline carries the tag and word index of each expected word, so that every wanted word arriving on the DQ lines is flagged with its request tag and its position in the burst. Words that were not wanted are never flagged.

Top module: `sdr_rd_seq`

## Requirements
- R1: One cycle after a request is accepted (req_valid and req_ready high at a clock edge), the command lines {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} carry READ = 4'b0101. For that cycle sd_ba carries the request bank and sd_addr carries the column in its low bits, with all higher address bits (including bit 10, auto-precharge) at 0.
- R2: req_len encodes the wanted word count n as n-1 (0..3). After accepting a request of n words, req_ready is low for the next n-1 cycles and high again in the n-th cycle. The next READ therefore reaches the bus exactly n cycles after the previous one.
- R3: Single-word requests (req_len = 0) can be accepted on every consecutive cycle, to the same bank or to different banks.
- R4: The first wanted word of a READ is flagged on rd_valid exactly CL cycles after the READ is on the bus. CL is 2 when cfg_cas3 = 0 and 3 when cfg_cas3 = 1.
- R5: Exactly the n wanted words of each request are flagged, on consecutive cycles, with rd_tag equal to the request tag and rd_idx counting 0 to n-1. No word beyond n is flagged, whether it is cut off by a later READ or left over at the end of a full burst.
- R6: When the next request is accepted in the first cycle req_ready allows, its word 0 is flagged in the cycle right after the previous request's last wanted word, with no idle cycle between them.
- R7: sd_dqm is 0 on every cycle.
- R8: rd_data equals the word on sd_dq_in in the same cycle.
- R9: While rst is high the command lines show NOP, req_ready is high and rd_valid is low.
- R10: Every cycle without a READ carries NOP = 4'b0111, including while the request queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 (static) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_len | input | 2 | Wanted word count minus one |
| req_tag | input | 4 | Request tag returned with its data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address lines |
| sd_dqm | output | DQ_W/8 | Byte data masks |
| sd_dq_in | input | DQ_W | Data captured from the DQ lines |
| rd_valid | output | 1 | Wanted read word present on rd_data |
| rd_data | output | DQ_W | Read data word |
| rd_tag | output | 4 | Tag of the request that owns the word |
| rd_idx | output | 2 | Word position within the request |

## Verification
The bench sweeps every pair of wanted lengths under both CAS latencies, with the second request offered at once, one cycle late or two cycles late. It also runs a long mixed stream of requests. A sequencer that spaced READs by CL instead of by the wanted length would show idle data cycles or overlapping flags, and a wrong latency tap would move every rd_valid pulse by a cycle. A design that let the tail of a truncated or finished burst through would flag words whose expected slot is empty. A design that mis-timed the busy window would either drop req_ready for single-word requests or accept a request before the previous wanted words are out.

// File: rtl/sdr_rd_pkg.sv
`timescale 1ns/1ps
package sdr_rd_pkg;

    // Programmed DRAM burst length and derived word-index width
    localparam int BURST_LEN = 4;
    localparam int LEN_W     = $clog2(BURST_LEN);
    localparam int TAG_W     = 4;

    // Supported CAS latencies
    localparam int MIN_CL    = 2;
    localparam int MAX_CL    = 3;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_READ = 4'b0101,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    // One expected data word travelling toward the DQ capture point
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [LEN_W-1:0] idx;
    } word_slot_t;

    // Progress of the burst whose wanted words are still being slotted
    typedef struct packed {
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] nxt;
        logic [TAG_W-1:0] tag;
    } burst_state_t;

endpackage

// File: rtl/sdr_rd_issue.sv
`timescale 1ns/1ps
module sdr_rd_issue
    import sdr_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    sd_cmd_e           cmd_q;
    logic [BANK_W-1:0] ba_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    // Column in the low bits; everything above, auto-precharge included, low
    always_comb begin
        addr_d              = '0;
        addr_d[COL_W-1:0]   = req_col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else if (accept) begin
            cmd_q  <= CMD_READ;
            ba_q   <= req_bank;
            addr_q <= addr_d;
        end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba   = ba_q;
    assign sd_addr = addr_q;

endmodule

// File: rtl/sdr_rd_slotgen.sv
`timescale 1ns/1ps
module sdr_rd_slotgen
    import sdr_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [LEN_W-1:0] req_len,
    input  logic [TAG_W-1:0] req_tag,
    output logic             ready,
    output word_slot_t       slot
);

    burst_state_t st_q;

    // The next READ may go out once every wanted word of this one has a slot;
    // its data then starts right after the last wanted word.
    assign ready = (st_q.left == '0);

    always_comb begin
        slot = '0;
        if (accept) begin
            slot.vld = 1'b1;
            slot.tag = req_tag;
            slot.idx = '0;
        end else if (st_q.left != '0) begin
            slot.vld = 1'b1;
            slot.tag = st_q.tag;
            slot.idx = st_q.nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (accept) begin
            st_q.left <= req_len;
            st_q.nxt  <= LEN_W'(1);
            st_q.tag  <= req_tag;
        end else if (st_q.left != '0) begin
            st_q.left <= st_q.left - LEN_W'(1);
            st_q.nxt  <= st_q.nxt + LEN_W'(1);
        end
    end

endmodule

// File: rtl/sdr_rd_tagpipe.sv
`timescale 1ns/1ps
module sdr_rd_tagpipe
    import sdr_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cas3,
    input  word_slot_t       slot_in,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [LEN_W-1:0] rd_idx
);

    // Stage s holds the slot whose READ was on the bus s cycles ago
    generate
        for (genvar s = 0; s <= MAX_CL; s++) begin : g_stage
            word_slot_t q;
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else     q <= slot_in;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else     q <= g_stage[s-1].q;
                end
            end
        end
    endgenerate

    word_slot_t tap;
    assign tap      = cfg_cas3 ? g_stage[MAX_CL].q : g_stage[MIN_CL].q;
    assign rd_valid = tap.vld;
    assign rd_tag   = tap.tag;
    assign rd_idx   = tap.idx;

endmodule

// File: rtl/sdr_rd_seq.sv
`timescale 1ns/1ps
module sdr_rd_seq
    import sdr_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 12,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cas3,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        req_len,
    input  logic [3:0]        req_tag,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQ_W/8-1:0] sd_dqm,
    input  logic [DQ_W-1:0]   sd_dq_in,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic [3:0]        rd_tag,
    output logic [1:0]        rd_idx
);

    localparam int DQM_W = DQ_W / 8;

    logic       accept;
    logic       ready;
    word_slot_t slot;

    assign accept    = req_valid && ready;
    assign req_ready = ready;

    sdr_rd_issue #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) u_issue (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_bank (req_bank),
        .req_col  (req_col),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr)
    );

    sdr_rd_slotgen u_slotgen (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .req_len (req_len),
        .req_tag (req_tag),
        .ready   (ready),
        .slot    (slot)
    );

    sdr_rd_tagpipe u_tagpipe (
        .clk      (clk),
        .rst      (rst),
        .cfg_cas3 (cfg_cas3),
        .slot_in  (slot),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_idx   (rd_idx)
    );

    // All bytes driven during reads
    assign sd_dqm  = {DQM_W{1'b0}};
    assign rd_data = sd_dq_in;

endmodule

// File: rtl/sdr_rd_seq_chk.sv
`timescale 1ns/1ps
module sdr_rd_seq_chk
    import sdr_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DQM_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_cas3,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BANK_W-1:0] req_bank,
    input logic [COL_W-1:0]  req_col,
    input logic [1:0]        req_len,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [COL_W-1:0]  sd_col,
    input logic [DQM_W-1:0]  sd_dqm,
    input logic              rd_valid,
    input logic [1:0]        rd_idx
);

    logic [3:0] cmd_w;
    assign cmd_w = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    a_r1_cmd_legal: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_NOP) || (cmd_w == CMD_READ));

    a_r1_read_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (cmd_w == CMD_READ && sd_ba == $past(req_bank) && sd_col == $past(req_col)));

    a_r10_nop_without_accept: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> (cmd_w == CMD_NOP));

    a_r2_busy_after_long: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len != 2'd0) |=> !req_ready);

    a_r3_single_rearms: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len == 2'd0) |=> req_ready);

    a_r4_first_word_cl2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_cas3 && cmd_w == CMD_READ) |-> ##2 (rd_valid && rd_idx == 2'd0));

    a_r4_first_word_cl3: assert property (@(posedge clk) disable iff (rst)
        (cfg_cas3 && cmd_w == CMD_READ) |-> ##3 (rd_valid && rd_idx == 2'd0));

    a_r5_idx_steps: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_idx != 2'd0) |-> ($past(rd_valid) && rd_idx == $past(rd_idx) + 2'd1));

    a_r7_dqm_low: assert property (@(posedge clk) disable iff (rst)
        sd_dqm == '0);

    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (cmd_w == CMD_NOP && !rd_valid));

endmodule

bind sdr_rd_seq sdr_rd_seq_chk #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .DQM_W  (DQM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_cas3  (cfg_cas3),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_col   (req_col),
    .req_len   (req_len),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_col    (sd_addr[COL_W-1:0]),
    .sd_dqm    (sd_dqm),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx)
);

// File: tb/sdr_rd_seq_test.sv
`timescale 1ns/1ps
module sdr_rd_seq_test;

    localparam int BANK_W = 2;
    localparam int COL_W  = 9;
    localparam int ADDR_W = 12;
    localparam int DQ_W   = 16;
    localparam int DQM_W  = DQ_W / 8;
    localparam int EXP_N  = 512;
    localparam int QMAX   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_cas3 = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [1:0]        req_len = '0;
    logic [3:0]        req_tag = '0;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BANK_W-1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic [DQM_W-1:0]  sd_dqm;
    logic [DQ_W-1:0]   sd_dq_in = '0;
    logic              rd_valid;
    logic [DQ_W-1:0]   rd_data;
    logic [3:0]        rd_tag;
    logic [1:0]        rd_idx;

    always #10 clk = ~clk;

    sdr_rd_seq #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W)
    ) uut (
        .clk (clk), .rst (rst), .cfg_cas3 (cfg_cas3),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_col (req_col), .req_len (req_len), .req_tag (req_tag),
        .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_ba (sd_ba), .sd_addr (sd_addr), .sd_dqm (sd_dqm), .sd_dq_in (sd_dq_in),
        .rd_valid (rd_valid), .rd_data (rd_data), .rd_tag (rd_tag), .rd_idx (rd_idx)
    );

    int tests_run = 0;
    int tests_failed = 0;

    // Expected per-cycle outcomes, indexed by negedge count since reset release
    bit               exp_read [EXP_N];
    logic [BANK_W-1:0] exp_ba  [EXP_N];
    logic [COL_W-1:0] exp_col  [EXP_N];
    bit               exp_v    [EXP_N];
    logic [3:0]       exp_tag  [EXP_N];
    logic [1:0]       exp_idx  [EXP_N];
    bit               exp_gl   [EXP_N];

    // Request queue for one run
    int q_len [QMAX];
    int q_tag [QMAX];
    int q_bank[QMAX];
    int q_col [QMAX];
    int q_gap [QMAX];
    int qn, qh, gap_left;

    int k, earliest, last_n, cl;
    bit had_prev;

    function automatic logic [DQ_W-1:0] pat(input int x);
        return DQ_W'(x * 945 + 197);
    endfunction

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", rq, what, k, act, exp);
        end
    endtask

    task automatic check_cycle();
        logic [3:0] cmd;
        cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (exp_read[k]) begin
            chk("R1", "command", cmd, 4'b0101);
            chk("R1", "bank", sd_ba, exp_ba[k]);
            chk("R1", "column", sd_addr[COL_W-1:0], exp_col[k]);
            chk("R1", "upper address", sd_addr >> COL_W, 0);
        end else begin
            chk("R10", "command", cmd, 4'b0111);
        end
        chk("R7", "dqm", sd_dqm, 0);
        chk((had_prev && last_n == 1) ? "R3" : "R2", "req_ready", req_ready, (k >= earliest));
        if (exp_v[k]) begin
            chk(exp_gl[k] ? "R6" : (exp_idx[k] == 2'd0 ? "R4" : "R5"), "rd_valid", rd_valid, 1);
            chk("R5", "rd_tag", rd_tag, exp_tag[k]);
            chk("R5", "rd_idx", rd_idx, exp_idx[k]);
            chk("R8", "rd_data", rd_data, pat(k - 1));
        end else begin
            chk("R5", "rd_valid idle", rd_valid, 0);
        end
    endtask

    task automatic drive();
        int n;
        if (qh < qn) begin
            if (gap_left > 0) begin
                gap_left--;
                req_valid = 1'b0;
            end else begin
                n = q_len[qh];
                req_valid = 1'b1;
                req_len   = 2'(n - 1);
                req_tag   = 4'(q_tag[qh]);
                req_bank  = BANK_W'(q_bank[qh]);
                req_col   = COL_W'(q_col[qh]);
                if (req_ready) begin
                    exp_read[k+1] = 1'b1;
                    exp_ba[k+1]   = BANK_W'(q_bank[qh]);
                    exp_col[k+1]  = COL_W'(q_col[qh]);
                    for (int i = 0; i < n; i++) begin
                        exp_v[k+1+cl+i]   = 1'b1;
                        exp_tag[k+1+cl+i] = 4'(q_tag[qh]);
                        exp_idx[k+1+cl+i] = 2'(i);
                    end
                    exp_gl[k+1+cl] = had_prev && (k == earliest);
                    earliest = k + n;
                    last_n   = n;
                    had_prev = 1'b1;
                    qh++;
                    if (qh < qn) gap_left = q_gap[qh];
                end
            end
        end else begin
            req_valid = 1'b0;
        end
        sd_dq_in = pat(k);
    endtask

    task automatic step();
        @(negedge clk);
        k++;
        check_cycle();
        drive();
    endtask

    task automatic run(input logic cas3);
        for (int i = 0; i < EXP_N; i++) begin
            exp_read[i] = 1'b0; exp_v[i] = 1'b0; exp_gl[i] = 1'b0;
            exp_ba[i] = '0; exp_col[i] = '0; exp_tag[i] = '0; exp_idx[i] = '0;
        end
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        cfg_cas3 = cas3;
        cl = cas3 ? 3 : 2;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk("R9", "reset ready", req_ready, 1);
        chk("R9", "reset rd_valid", rd_valid, 0);
        rst = 1'b0;
        k = 0; earliest = 0; last_n = 0; had_prev = 1'b0; qh = 0;
        gap_left = (qn > 0) ? q_gap[0] : 0;
        sd_dq_in = pat(0);
        while (qh < qn) step();
        repeat (10) step();
    endtask

    initial begin
        // Every pair of lengths, both latencies, offered at once or late
        for (int c = 0; c < 2; c++)
            for (int a = 1; a <= 4; a++)
                for (int b = 1; b <= 4; b++)
                    for (int g = 0; g < 3; g++) begin
                        qn = 2;
                        q_len[0] = a; q_tag[0] = (a * 4 + b) % 16; q_bank[0] = a % 4;
                        q_col[0] = 400 + a; q_gap[0] = g;
                        q_len[1] = b; q_tag[1] = (a * 4 + b + 7) % 16; q_bank[1] = (a + b * g) % 4;
                        q_col[1] = 17 * b + g; q_gap[1] = g;
                        run(c[0]);
                    end
        // Long mixed stream including single-word runs (R3)
        for (int c = 0; c < 2; c++) begin
            qn = 48;
            for (int i = 0; i < qn; i++) begin
                q_len[i]  = (i >= 10 && i < 16) ? 1 : ((i * 5 + i / 3) % 4) + 1;
                q_tag[i]  = i % 16;
                q_bank[i] = (i * 3) % 4;
                q_col[i]  = (i * 37) % 512;
                q_gap[i]  = (i % 7 == 3) ? 2 : 0;
            end
            run(c[0]);
        end
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(20 * 150000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule